// File: doc/BRIEF.md
# Random Word Output Buffer

This block sits at the end of an entropy pipeline and holds one random word for a bus master. The upstream generator offers a word with a valid strobe. The buffer takes it only while it is empty, using a ready/valid handshake. Once a word is held, a data-ready flag is set and the generator is stalled. Software polls the status register, or waits for the interrupt, and then reads the data register. That read consumes the word: the flag clears and the generator may deliver the next word.

The buffer does not depend on the enable bit in the control register. The enable bit only drives the upstream generator, so a word still in flight can land and raise data-ready after software has disabled the pipeline. Whenever no valid word is held, the data register reads as zero. A seed error reported by the pipeline wipes the held word at once. Software that reads zero after seeing data-ready therefore knows the word was discarded. The status register shows the live seed error level.

Top module: `randword_buffer`

## Requirements
- R1: After reset, the status and control registers read 0, the data register reads 0, `irq` and `gen_enable` are 0, and `gen_ready` is 1.
- R2: When `gen_valid` and `gen_ready` are both 1 at a clock edge, then from the next cycle status bit 0 (data-ready) is 1, the data register (offset 0x8) reads the accepted word, and `gen_ready` is 0.
- R3: While a word is held, `gen_ready` stays 0, and a word offered on `gen_valid` does not replace the held word.
- R4: A read cycle of the data register (`bus_sel`=1, `bus_wr`=0, `bus_addr`=0x8) while a word is held returns that word in the same cycle. From the next cycle data-ready is 0 and `gen_ready` is 1.
- R5: A read of the data register while data-ready is 0 returns 0 and does not change the state.
- R6: While `seed_err` is 1, status bit 2 reads 1 in the same cycle and `gen_ready` is 0. From the cycle after `seed_err` is high, data-ready is 0 and the data register reads 0.
- R7: A write to the control register (offset 0x0) stores bit 0 as enable, which drives `gen_enable`, and bit 1 as interrupt enable. Reading the control register returns these two bits and 0 in all other bits.
- R8: A word is accepted and data-ready rises even while the enable bit is 0.
- R9: `irq` is 1 exactly when the interrupt enable bit is 1 and data-ready is 1.
- R10: Writes to the status offset (0x4) and the data offset (0x8) have no effect, and a read of any offset other than 0x0, 0x4 or 0x8 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gen_valid | input | 1 | Generator offers a word |
| gen_word | input | DATA_W | Word from the generator |
| gen_ready | output | 1 | Buffer is able to take a word |
| seed_err | input | 1 | Seed error level from the pipeline |
| bus_sel | input | 1 | Register access cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| gen_enable | output | 1 | Enable bit to the generator |
| irq | output | 1 | Data-ready interrupt |

## Verification
An occupancy flag stuck in the wrong state shows in the very next cycle. It appears on `gen_ready`, on status bit 0 and on `irq`, and a data read returns either a stale word or zero where the other was expected. A held word that is corrupted, or replaced by a second offer, shows in the same data read that should return it. The bench therefore offers a second word on every fill and compares each read with the pushed value. A missed seed-error wipe shows one cycle after the error as a nonzero data read. Every interrupt enable and control enable combination is swept against many word patterns.

// File: rtl/rwb_pkg.sv
package rwb_pkg;

    // which register a bus cycle addresses
    typedef enum logic [1:0] {
        RWB_NONE = 2'd0,
        RWB_CTRL = 2'd1,
        RWB_STAT = 2'd2,
        RWB_DATA = 2'd3
    } rwb_reg_e;

    // control register contents
    typedef struct packed {
        logic ie;
        logic en;
    } rwb_ctrl_t;

    // status bit positions decoded by software
    localparam int unsigned STAT_RDY_BIT  = 0;
    localparam int unsigned STAT_SEED_BIT = 2;

endpackage

// File: rtl/rwb_decode.sv
module rwb_decode
    import rwb_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned OFF_CTRL = 0,
    parameter int unsigned OFF_STAT = 4,
    parameter int unsigned OFF_DATA = 8
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output rwb_reg_e          reg_sel,
    output logic              ctrl_wr,
    output logic              data_rd
);

    always_comb begin
        reg_sel = RWB_NONE;
        if (bus_sel) begin
            if (bus_addr == ADDR_W'(OFF_CTRL)) begin
                reg_sel = RWB_CTRL;
            end else if (bus_addr == ADDR_W'(OFF_STAT)) begin
                reg_sel = RWB_STAT;
            end else if (bus_addr == ADDR_W'(OFF_DATA)) begin
                reg_sel = RWB_DATA;
            end
        end
        ctrl_wr = (reg_sel == RWB_CTRL) && bus_wr;
        data_rd = (reg_sel == RWB_DATA) && !bus_wr;
    end

endmodule

// File: rtl/rwb_ctrl.sv
module rwb_ctrl
    import rwb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_stb,
    input  logic [1:0] wr_bits,
    output rwb_ctrl_t ctrl
);

    rwb_ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_stb) begin
            ctrl_d.en = wr_bits[0];
            ctrl_d.ie = wr_bits[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/rwb_hold.sv
module rwb_hold #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_valid,
    input  logic [DATA_W-1:0] gen_word,
    input  logic              seed_err,
    input  logic              consume,
    output logic              gen_ready,
    output logic              full,
    output logic [DATA_W-1:0] word
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] word;
    } hold_t;

    hold_t hold_d, hold_q;
    logic  take;

    always_comb begin
        hold_d    = hold_q;
        gen_ready = !hold_q.full && !seed_err;
        take      = gen_valid && gen_ready;
        if (seed_err) begin
            hold_d.full = 1'b0;
            hold_d.word = '0;
        end else if (consume && hold_q.full) begin
            hold_d.full = 1'b0;
            hold_d.word = '0;
        end else if (take) begin
            hold_d.full = 1'b1;
            hold_d.word = gen_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign full = hold_q.full;
    assign word = hold_q.word;

endmodule

// File: rtl/rwb_rmux.sv
module rwb_rmux
    import rwb_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  rwb_reg_e          reg_sel,
    input  rwb_ctrl_t         ctrl,
    input  logic              full,
    input  logic              seed_err,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        case (reg_sel)
            RWB_CTRL: begin
                rdata[0] = ctrl.en;
                rdata[1] = ctrl.ie;
            end
            RWB_STAT: begin
                rdata[STAT_RDY_BIT]  = full;
                rdata[STAT_SEED_BIT] = seed_err;
            end
            RWB_DATA: begin
                rdata = full ? word : '0;
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/randword_buffer.sv
module randword_buffer
    import rwb_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned OFF_CTRL = 0,
    parameter int unsigned OFF_STAT = 4,
    parameter int unsigned OFF_DATA = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_valid,
    input  logic [DATA_W-1:0] gen_word,
    output logic              gen_ready,
    input  logic              seed_err,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              gen_enable,
    output logic              irq
);

    rwb_reg_e          reg_sel;
    logic              ctrl_wr;
    logic              data_rd;
    rwb_ctrl_t         ctrl;
    logic              full_w;
    logic [DATA_W-1:0] word_w;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:2];

    rwb_decode #(
        .ADDR_W  (ADDR_W),
        .OFF_CTRL(OFF_CTRL),
        .OFF_STAT(OFF_STAT),
        .OFF_DATA(OFF_DATA)
    ) u_decode (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .reg_sel (reg_sel),
        .ctrl_wr (ctrl_wr),
        .data_rd (data_rd)
    );

    rwb_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (ctrl_wr),
        .wr_bits(bus_wdata[1:0]),
        .ctrl   (ctrl)
    );

    rwb_hold #(
        .DATA_W(DATA_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .gen_valid(gen_valid),
        .gen_word (gen_word),
        .seed_err (seed_err),
        .consume  (data_rd),
        .gen_ready(gen_ready),
        .full     (full_w),
        .word     (word_w)
    );

    rwb_rmux #(
        .DATA_W(DATA_W)
    ) u_rmux (
        .reg_sel (reg_sel),
        .ctrl    (ctrl),
        .full    (full_w),
        .seed_err(seed_err),
        .word    (word_w),
        .rdata   (bus_rdata)
    );

    assign gen_enable = ctrl.en;
    assign irq        = ctrl.ie & full_w;

endmodule

// File: rtl/rwb_chk.sv
module rwb_chk #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned OFF_DATA = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gen_valid,
    input logic [DATA_W-1:0] gen_word,
    input logic              gen_ready,
    input logic              seed_err,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              full,
    input logic [DATA_W-1:0] word
);

    logic rd_data;
    assign rd_data = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFF_DATA));

    // R2
    accept_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_valid && gen_ready |=> full && (word == $past(gen_word)));

    // R3
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !gen_ready);

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && !rd_data && !seed_err |=> full && $stable(word));

    // R4
    consume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data && full && !seed_err |=> !full);

    // R5
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data && !full |-> bus_rdata == '0);

    // R6
    seed_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_err |=> !full && (word == '0));

    // R9
    irq_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> full);

endmodule

bind randword_buffer rwb_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .OFF_DATA(OFF_DATA)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gen_valid(gen_valid),
    .gen_word (gen_word),
    .gen_ready(gen_ready),
    .seed_err (seed_err),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .full     (full_w),
    .word     (word_w)
);

// File: tb/randword_buffer_test.sv
`timescale 1ns/1ps
module randword_buffer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_valid = 1'b0;
    logic [31:0] gen_word = '0;
    logic        gen_ready;
    logic        seed_err = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        gen_enable;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    randword_buffer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .gen_valid (gen_valid),
        .gen_word  (gen_word),
        .gen_ready (gen_ready),
        .seed_err  (seed_err),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gen_enable(gen_enable),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic push(input logic [31:0] w, output logic rdy);
        gen_valid = 1'b1; gen_word = w;
        #1 rdy = gen_ready;
        @(posedge clk); @(negedge clk);
        gen_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic        r;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 gen_ready", {31'b0, gen_ready}, 32'd1);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 gen_enable", {31'b0, gen_enable}, 32'd0);
        rd(4'h4, v); chk("R1 status", v, 32'd0);
        rd(4'h0, v); chk("R1 control", v, 32'd0);
        rd(4'h8, v); chk("R1 data", v, 32'd0);

        for (int c = 0; c < 4; c++) begin
            wr(4'h0, 32'hFFFF_FFF0 | c);
            rd(4'h0, v); chk("R7 control readback", v, c);
            chk("R7 gen_enable", {31'b0, gen_enable}, c & 1);
            for (int k = 0; k < 32; k++) begin
                w = (32'h9E37_79B9 * (k + c * 32 + 1)) ^ (32'd1 << k);
                push(w, r);
                chk("R2 ready before push", {31'b0, r}, 32'd1);
                rd(4'h4, v);
                chk((c & 1) ? "R2 data-ready set" : "R8 data-ready with enable low", v, 32'd1);
                chk("R9 irq while full", {31'b0, irq}, (c >> 1) & 1);
                chk("R3 gen_ready low", {31'b0, gen_ready}, 32'd0);
                push(~w, r);
                chk("R3 second offer refused", {31'b0, r}, 32'd0);
                rd(4'h8, v); chk("R4 data read", v, w);
                rd(4'h4, v); chk("R4 status after read", v, 32'd0);
                chk("R9 irq after read", {31'b0, irq}, 32'd0);
                chk("R4 gen_ready after read", {31'b0, gen_ready}, 32'd1);
                rd(4'h8, v); chk("R5 empty data read", v, 32'd0);
            end
        end

        // R6 seed error wipes a held word
        push(32'hA5A5_1234, r);
        seed_err = 1'b1;
        #1;
        chk("R6 gen_ready during error", {31'b0, gen_ready}, 32'd0);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'h4;
        #0.5 chk("R6 status same cycle", bus_rdata, 32'd5);
        bus_sel = 1'b0;
        @(posedge clk); @(negedge clk);
        rd(4'h4, v); chk("R6 status after wipe", v, 32'd4);
        rd(4'h8, v); chk("R6 data after wipe", v, 32'd0);
        push(32'h1111_2222, r);
        chk("R6 offer refused during error", {31'b0, r}, 32'd0);
        seed_err = 1'b0;
        rd(4'h4, v); chk("R6 no word after error", v, 32'd0);
        push(32'h3333_4444, r);
        rd(4'h4, v); chk("R6 recovery fill", v, 32'd1);

        // R10 ignored writes and unmapped reads
        wr(4'h4, 32'hFFFF_FFFF);
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h0, v); chk("R10 control untouched", v, 32'd3);
        rd(4'h4, v); chk("R10 status untouched", v, 32'd1);
        for (int a = 0; a < 16; a++) begin
            if (a != 0 && a != 4 && a != 8) begin
                rd(a[3:0], v); chk("R10 unmapped read", v, 32'd0);
            end
        end
        rd(4'h8, v); chk("R10 word untouched", v, 32'h3333_4444);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule